// File: doc/BRIEF.md
# Five-Instruction Single-Cycle Core

This block is a small processor core that completes one instruction per clock. It runs a load/store instruction set of five operations: register add, register subtract, word load, word store, and a conditional jump to an address held in a register. Each cycle the core places its program counter on the instruction port. It decodes the returned word, reads two registers and computes its result. At the next rising edge it commits the register write and the new program counter.

The core connects to two memories outside it. The instruction memory is read-only and combinational. The data memory has a combinational read and a write that lands on the clock edge. All instruction words are 32 bits. The opcode sits in bits 31:26, source register A (rs) in 25:21, source register B (rt) in 20:16, the destination rd in 15:11, and the 16-bit immediate in 15:0.

Top module: `mini_core`

## Requirements
- R1: Opcode 0 (add) writes the sum of rs and rt into register rd.
- R2: Opcode 1 (subtract) writes rs minus rt into register rd, wrapping modulo 2^32.
- R3: Opcode 2 (load) reads the data word at rs plus the sign-extended immediate and writes it into register rt.
- R4: Opcode 3 (store) drives address rs plus the sign-extended immediate and data rt, with the data write enable high.
- R5: Opcode 4 (branch-if-zero) sets the next program counter to the value of rs when rt is zero. Otherwise the program counter advances by 4.
- R6: The 16-bit immediate is always sign-extended, so an immediate of 0xFFF8 subtracts 8 from the base.
- R7: Register 0 reads as zero, and writes to it have no effect.
- R8: While reset is low the program counter is 0. After reset, every instruction other than a taken branch advances it by 4.
- R9: A register written in one cycle can be read by the instruction of the next cycle.
- R10: An opcode above 4 writes no register and no memory, and the program counter advances by 4.
- R11: The data write enable is high only for a store. The register write enable is high only for add, subtract and load, so the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 32 | Program counter, the instruction fetch address |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Data address, rs plus sign-extended immediate |
| dmem_wdata | output | 32 | Store data, the value of rt |
| dmem_we | output | 1 | Data write enable, high during a store |
| dmem_rdata | input | 32 | Data word at dmem_addr |

## Verification
Assertions check on every cycle that the program counter advances by 4 after any non-branch instruction. They also check that the data write enable tracks the store opcode exactly, that the two write enables never overlap, and that an unknown opcode stays silent. Arithmetic results, sign-extended addresses, register 0 behaviour, back-to-back register use and both outcomes of the branch are not visible in any single cycle. The bench's program shows them, through the store traffic and the fetch address sequence it compares against a scoreboard.

// File: rtl/core_pkg.sv
package core_pkg;
    localparam int OPW = 6;

    localparam logic [OPW-1:0] OPC_ADD   = 6'd0;
    localparam logic [OPW-1:0] OPC_SUB   = 6'd1;
    localparam logic [OPW-1:0] OPC_LOAD  = 6'd2;
    localparam logic [OPW-1:0] OPC_STORE = 6'd3;
    localparam logic [OPW-1:0] OPC_BRZ   = 6'd4;

    typedef enum logic [2:0] {
        K_ADD,
        K_SUB,
        K_LOAD,
        K_STORE,
        K_BRZ,
        K_NOP
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  rf_we;
        logic  dm_we;
        logic  sub_en;
        logic  wb_mem;
        logic  dst_rd;
        logic  brz;
    } ctrl_t;
endpackage

// File: rtl/core_regfile.sv
module core_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ra_a,
    input  logic [AW-1:0]   ra_b,
    output logic [XLEN-1:0] rd_a,
    output logic [XLEN-1:0] rd_b,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd
);
    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];
endmodule

// File: rtl/core_decode.sv
module core_decode
    import core_pkg::*;
(
    input  logic [OPW-1:0] opcode,
    output ctrl_t          ctrl
);
    always_comb begin
        ctrl = '{kind: K_NOP, rf_we: 1'b0, dm_we: 1'b0, sub_en: 1'b0,
                 wb_mem: 1'b0, dst_rd: 1'b0, brz: 1'b0};
        unique case (opcode)
            OPC_ADD: begin
                ctrl.kind   = K_ADD;
                ctrl.rf_we  = 1'b1;
                ctrl.dst_rd = 1'b1;
            end
            OPC_SUB: begin
                ctrl.kind   = K_SUB;
                ctrl.rf_we  = 1'b1;
                ctrl.dst_rd = 1'b1;
                ctrl.sub_en = 1'b1;
            end
            OPC_LOAD: begin
                ctrl.kind   = K_LOAD;
                ctrl.rf_we  = 1'b1;
                ctrl.wb_mem = 1'b1;
            end
            OPC_STORE: begin
                ctrl.kind   = K_STORE;
                ctrl.dm_we  = 1'b1;
            end
            OPC_BRZ: begin
                ctrl.kind   = K_BRZ;
                ctrl.brz    = 1'b1;
            end
            default: ctrl.kind = K_NOP;
        endcase
    end
endmodule

// File: rtl/core_exec.sv
module core_exec #(
    parameter int XLEN = 32,
    parameter int IMMW = 16,
    parameter int STEP = 4
) (
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    input  logic [IMMW-1:0] imm,
    input  logic [XLEN-1:0] pc,
    input  logic            sub_en,
    input  logic            brz,
    output logic [XLEN-1:0] alu_y,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] next_pc
);
    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] pc_seq;
    logic            take;

    assign imm_sx   = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
    assign alu_y    = sub_en ? (rs_val - rt_val) : (rs_val + rt_val);
    assign mem_addr = rs_val + imm_sx;
    assign pc_seq   = pc + XLEN'(STEP);
    assign take     = brz && (rt_val == '0);
    assign next_pc  = take ? rs_val : pc_seq;
endmodule

// File: rtl/mini_core.sv
module mini_core
    import core_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [31:0]     imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);
    localparam int AW   = $clog2(NREG);
    localparam int IMMW = 16;

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_d;
    ctrl_t           ctrl;
    logic [AW-1:0]   f_rs, f_rt, f_rd, wa;
    logic [XLEN-1:0] rs_val, rt_val, alu_y, wd;
    logic            rf_we;

    assign f_rs = AW'(imem_rdata[25:21]);
    assign f_rt = AW'(imem_rdata[20:16]);
    assign f_rd = AW'(imem_rdata[15:11]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    core_decode u_dec (
        .opcode (imem_rdata[31:26]),
        .ctrl   (ctrl)
    );

    core_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk  (clk),
        .rst_n(rst_n),
        .ra_a (f_rs),
        .ra_b (f_rt),
        .rd_a (rs_val),
        .rd_b (rt_val),
        .we   (rf_we),
        .wa   (wa),
        .wd   (wd)
    );

    core_exec #(.XLEN(XLEN), .IMMW(IMMW), .STEP(4)) u_ex (
        .rs_val  (rs_val),
        .rt_val  (rt_val),
        .imm     (imem_rdata[IMMW-1:0]),
        .pc      (pc_q),
        .sub_en  (ctrl.sub_en),
        .brz     (ctrl.brz),
        .alu_y   (alu_y),
        .mem_addr(dmem_addr),
        .next_pc (pc_d)
    );

    assign rf_we      = ctrl.rf_we;
    assign wa         = ctrl.dst_rd ? f_rd : f_rt;
    assign wd         = ctrl.wb_mem ? dmem_rdata : alu_y;
    assign imem_addr  = pc_q;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.dm_we;
endmodule

// File: rtl/mini_core_chk.sv
module mini_core_chk
    import core_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] imem_addr,
    input logic [31:0]     imem_rdata,
    input logic            dmem_we,
    input logic            rf_we
);
    logic [OPW-1:0] op;
    assign op = imem_rdata[31:26];

    always @(posedge clk) begin
        if (!rst_n) AST_RESET_PC: assert (imem_addr == '0); // R8
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OPC_BRZ) |=> (imem_addr == $past(imem_addr) + XLEN'(4))); // R8

    AST_STORE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (op == OPC_STORE)); // R11

    AST_STORE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OPC_STORE) |-> dmem_we); // R4

    AST_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && dmem_we)); // R11

    AST_NOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (op > OPC_BRZ) |-> (!rf_we && !dmem_we)); // R10
endmodule

bind mini_core mini_core_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .imem_rdata(imem_rdata),
    .dmem_we   (dmem_we),
    .rf_we     (rf_we)
);

// File: tb/tb_mini_core.sv
module tb_mini_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] pc;
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
        string       req;
    } exp_t;
    exp_t sb [$];

    always #4 clk = ~clk;

    mini_core dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .imem_addr (imem_addr),
        .imem_rdata(imem_rdata),
        .dmem_addr (dmem_addr),
        .dmem_wdata(dmem_wdata),
        .dmem_we   (dmem_we),
        .dmem_rdata(dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];
    always @(posedge clk) if (rst_n && dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    function automatic logic [31:0] enc(int op, int rs, int rt, logic [15:0] low);
        return {op[5:0], rs[4:0], rt[4:0], low};
    endfunction

    function automatic logic [15:0] rdf(int rd);
        return {rd[4:0], 11'd0};
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push(logic [31:0] pc, logic we, logic [31:0] addr, logic [31:0] data, string req);
        exp_t e;
        e.pc = pc; e.we = we; e.addr = addr; e.data = data; e.req = req;
        sb.push_back(e);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // driver: program, data, scoreboard contents, reset
    initial begin
        for (int i = 0; i < 64; i++) begin imem[i] = 32'd0; dmem[i] = 32'd0; end
        dmem[0] = 32'd5; dmem[1] = 32'd7; dmem[2] = 32'd80; dmem[3] = 32'd100;
        imem[0]  = enc(2, 0, 1, 16'd0);         // r1 = 5
        imem[1]  = enc(2, 0, 2, 16'd4);         // r2 = 7
        imem[2]  = enc(0, 1, 2, rdf(3));        // r3 = 12
        imem[3]  = enc(1, 1, 2, rdf(4));        // r4 = -2
        imem[4]  = enc(3, 0, 3, 16'd64);
        imem[5]  = enc(3, 0, 4, 16'd68);
        imem[6]  = enc(2, 0, 5, 16'd8);         // r5 = 80
        imem[7]  = enc(3, 5, 1, 16'hFFF8);      // addr 72
        imem[8]  = enc(0, 1, 2, rdf(0));        // write r0
        imem[9]  = enc(3, 0, 0, 16'd76);
        imem[10] = enc(7, 1, 1, rdf(1));        // unknown op
        imem[11] = enc(3, 0, 1, 16'd84);
        imem[12] = enc(2, 0, 6, 16'd12);        // r6 = 100
        imem[13] = enc(4, 6, 1, 16'd0);         // not taken
        imem[14] = enc(4, 6, 0, 16'd0);         // taken to 100
        imem[15] = enc(3, 0, 1, 16'd88);        // skipped
        imem[25] = enc(3, 0, 3, 16'd92);
        imem[26] = enc(4, 0, 0, 16'd0);         // taken to 0

        push(0,   0, 0, 0, "R3");
        push(4,   0, 0, 0, "R3");
        push(8,   0, 0, 0, "R9");
        push(12,  0, 0, 0, "R2");
        push(16,  1, 64, 32'd12, "R1 R4");
        push(20,  1, 68, 32'hFFFF_FFFE, "R2");
        push(24,  0, 0, 0, "R11");
        push(28,  1, 72, 32'd5, "R6 R3");
        push(32,  0, 0, 0, "R11");
        push(36,  1, 76, 32'd0, "R7");
        push(40,  0, 0, 0, "R10");
        push(44,  1, 84, 32'd5, "R10");
        push(48,  0, 0, 0, "R11");
        push(52,  0, 0, 0, "R5");
        push(56,  0, 0, 0, "R5");
        push(100, 1, 92, 32'd12, "R5");
        push(104, 0, 0, 0, "R8");
        push(0,   0, 0, 0, "R5");

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(imem_addr == 32'd0, "R8", "reset pc", imem_addr, 32'd0);
        check(dmem_we == 1'b0, "R11", "reset dmem_we", {31'd0, dmem_we}, 32'd0);
        rst_n = 1'b1;
    end

    // monitor: pop expected items and compare once per cycle
    initial begin
        exp_t e;
        @(posedge rst_n);
        while (sb.size() != 0) begin
            #1;
            e = sb.pop_front();
            check(imem_addr == e.pc, e.req, "pc", imem_addr, e.pc);
            check(dmem_we == e.we, e.req, "dmem_we", {31'd0, dmem_we}, {31'd0, e.we});
            if (e.we) begin
                check(dmem_addr == e.addr, e.req, "dmem_addr", dmem_addr, e.addr);
                check(dmem_wdata == e.data, e.req, "dmem_wdata", dmem_wdata, e.data);
            end
            @(negedge clk);
        end
        finish_run();
    end

    initial begin
        #(8 * 5000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end
endmodule